// File: doc/BRIEF.md
# Dual-Bus Program Fetch Steering

This block sits between an 8051-class core and two multiplexed address/data buses that can serve program memory. The primary bus carries the low address byte and the opcode on port 0 and the high address byte on port 2. The secondary bus carries the low address byte and the opcode on port 5 and the high byte on port 6. Two mode pins and the fetch address decide which bus serves each fetch: the bus-enable pin and the external-access pin. The chosen bus gets an address-latch pulse and a read strobe of its own, and the byte returned on that bus goes back to the core as the opcode.

The core supplies the machine-cycle phase as an index from 0 to 11. Six phases make one fetch slot, so a machine cycle holds two slots. If the core flags an external data-memory access in a machine cycle, the second slot is given up to that data cycle on the primary bus, and no fetch is steered in it. While bus-enable is low, ports 5 and 6 are not a bus. They act as two plain byte-wide I/O registers, written and read through a small special-function-register access port.

Every output is registered. A phase index applied before a rising clock edge shows its effect on the outputs just after that edge.

Top module: `pfs_fetch_steer`

## Requirements
- R1: With bus_en=0 and ext_acc=0, every fetch address from 0000H to FFFFH is served by the primary bus: pri_rd pulses and sec_rd stays low.
- R2: With bus_en=0 and ext_acc=1, the mode is invalid. ale, pri_rd and sec_rd all stay low, no opcode_vld is produced, and err is high in the cycle after each such cycle.
- R3: With bus_en=1 and ext_acc=0, every fetch address from 0000H to FFFFH is served by the secondary bus: sec_rd pulses and pri_rd stays low.
- R4: With bus_en=1 and ext_acc=1, addresses below 2000H are served by the secondary bus and addresses of 2000H and above are served by the primary bus.
- R5: In the output cycle where ale is high, the fetch address is on the selected bus. For the primary bus the low byte is on p0_out with p0_oe=1 and the high byte is on p2_out. For the secondary bus the low byte is on p5_out with p5_oe=1 and the high byte is on p6_out.
- R6: Phase 0 and phase 6 start the two slots. ale follows phase 0 or 6 of an active slot, and the strobe of the selected bus follows phases 3, 4 and 5 (or 9, 10 and 11). Both buses use the same timing, the two strobes are never high together, and ale never coincides with a strobe.
- R7: When xdata_cyc=1, the second slot (phases 6 to 11) produces no ale, no pri_rd and no sec_rd on either bus, so data-memory cycles never reach the secondary bus. The first slot still fetches normally.
- R8: The opcode is sampled at the last strobe phase of a slot, from p0_in for the primary bus or from p5_in for the secondary bus. It is presented on opcode with a one-cycle opcode_vld pulse.
- R9: While bus_en=0, a byte write to SFR address 91H loads the port-5 register and a write to A1H loads the port-6 register. p5_out and p6_out show these registers, and sfr_rdata returns them one cycle after a read. Writes to the bit-addressable row addresses 90H and A0H do not change them.
- R10: A read or write of 91H or A1H while bus_en=1 raises err in the next cycle. Such a write leaves the register unchanged, and such a read returns 00H.
- R11: After reset, ale, pri_rd, sec_rd, opcode_vld and err are 0, and both port registers hold FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Enables the secondary program bus |
| ext_acc | input | 1 | External-access mode pin |
| fetch_req | input | 1 | Core requests a program fetch in the current slot |
| fetch_addr | input | 16 | Program fetch address |
| phase | input | 4 | Machine-cycle phase index, 0 to 11 |
| xdata_cyc | input | 1 | This machine cycle performs an external data-memory access |
| p0_in | input | 8 | Byte read back on the primary bus |
| p5_in | input | 8 | Byte read back on the secondary bus |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_rd | input | 1 | SFR read strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| ale | output | 1 | Address latch enable |
| pri_rd | output | 1 | Primary-bus program read strobe, active high |
| sec_rd | output | 1 | Secondary-bus program read strobe, active high |
| p0_out | output | 8 | Primary low address byte |
| p0_oe | output | 1 | Primary low-byte output enable |
| p2_out | output | 8 | Primary high address byte |
| p5_out | output | 8 | Secondary low address byte, or port-5 register |
| p5_oe | output | 1 | Port-5 output enable |
| p6_out | output | 8 | Secondary high address byte, or port-6 register |
| opcode | output | 8 | Fetched opcode byte |
| opcode_vld | output | 1 | Opcode valid pulse |
| err | output | 1 | Invalid mode or forbidden port access |
| sfr_rdata | output | 8 | SFR read data |

## Verification
A program fetch and an external data-memory access can fall in the same machine cycle. The bench provokes this by raising xdata_cyc together with fetch_req for a whole machine cycle, on each bus and in each mode. It then counts ale pulses, strobe cycles and opcode pulses: it expects exactly one fetch slot on the selected bus and nothing in phases 6 to 11. The same collision is also checked cycle by cycle, for both buses, against the rule that second-slot activity must be absent.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_PRI  = 2'd1,
    BUS_SEC  = 2'd2
  } bus_sel_e;

  localparam int PH_W    = 4;
  localparam int SLOT_PH = 6;
endpackage

// File: rtl/pfs_mode_decode.sv
module pfs_mode_decode
  import pfs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SPLIT = 16'h2000
) (
  input  logic              bus_en,
  input  logic              ext_acc,
  input  logic [ADDR_W-1:0] addr,
  output bus_sel_e          sel,
  output logic              invalid
);
  always_comb begin
    invalid = !bus_en && ext_acc;
    if (invalid)       sel = BUS_NONE;
    else if (!bus_en)  sel = BUS_PRI;
    else if (!ext_acc) sel = BUS_SEC;
    else if (addr < SPLIT) sel = BUS_SEC;
    else               sel = BUS_PRI;
  end
endmodule

// File: rtl/pfs_slot_timing.sv
module pfs_slot_timing #(
  parameter int PH_W    = 4,
  parameter int SLOT_PH = 6
) (
  input  logic [PH_W-1:0] phase,
  output logic            slot_first,
  output logic            slot_last,
  output logic            addr_win,
  output logic            strobe_win,
  output logic            second_slot
);
  localparam logic [PH_W-1:0] SLOT_V   = PH_W'(SLOT_PH);
  localparam logic [PH_W-1:0] LAST_V   = PH_W'(SLOT_PH - 1);
  localparam logic [PH_W-1:0] STROBE_V = PH_W'(SLOT_PH / 2);

  logic [PH_W-1:0] off;

  always_comb begin
    second_slot = (phase >= SLOT_V);
    off         = second_slot ? (phase - SLOT_V) : phase;
    slot_first  = (off == '0);
    slot_last   = (off == LAST_V);
    addr_win    = (off < STROBE_V);
    strobe_win  = (off >= STROBE_V);
  end
endmodule

// File: rtl/pfs_port_regs.sv
module pfs_port_regs #(
  parameter int DATA_W = 8,
  parameter int SFR_AW = 8,
  parameter logic [SFR_AW-1:0] P5_ADDR = 8'h91,
  parameter logic [SFR_AW-1:0] P6_ADDR = 8'hA1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              sfr_wr,
  input  logic              sfr_rd,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] p5_reg,
  output logic [DATA_W-1:0] p6_reg,
  output logic [DATA_W-1:0] sfr_rdata,
  output logic              io_err
);
  logic hit5, hit6;

  assign hit5   = (sfr_addr == P5_ADDR);
  assign hit6   = (sfr_addr == P6_ADDR);
  assign io_err = bus_en && (sfr_wr || sfr_rd) && (hit5 || hit6);

  always_ff @(posedge clk) begin
    if (rst) begin
      p5_reg    <= '1;
      p6_reg    <= '1;
      sfr_rdata <= '0;
    end else begin
      if (sfr_wr && !bus_en && hit5) p5_reg <= sfr_wdata;
      if (sfr_wr && !bus_en && hit6) p6_reg <= sfr_wdata;
      if (sfr_rd && !bus_en && hit5)      sfr_rdata <= p5_reg;
      else if (sfr_rd && !bus_en && hit6) sfr_rdata <= p6_reg;
      else                                sfr_rdata <= '0;
    end
  end
endmodule

// File: rtl/pfs_fetch_steer.sv
module pfs_fetch_steer
  import pfs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SFR_AW = 8,
  parameter logic [2*DATA_W-1:0] SPLIT = 16'h2000,
  parameter logic [SFR_AW-1:0] P5_ADDR = 8'h91,
  parameter logic [SFR_AW-1:0] P6_ADDR = 8'hA1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_en,
  input  logic                ext_acc,
  input  logic                fetch_req,
  input  logic [2*DATA_W-1:0] fetch_addr,
  input  logic [PH_W-1:0]     phase,
  input  logic                xdata_cyc,
  input  logic [DATA_W-1:0]   p0_in,
  input  logic [DATA_W-1:0]   p5_in,
  input  logic                sfr_wr,
  input  logic                sfr_rd,
  input  logic [SFR_AW-1:0]   sfr_addr,
  input  logic [DATA_W-1:0]   sfr_wdata,
  output logic                ale,
  output logic                pri_rd,
  output logic                sec_rd,
  output logic [DATA_W-1:0]   p0_out,
  output logic                p0_oe,
  output logic [DATA_W-1:0]   p2_out,
  output logic [DATA_W-1:0]   p5_out,
  output logic                p5_oe,
  output logic [DATA_W-1:0]   p6_out,
  output logic [DATA_W-1:0]   opcode,
  output logic                opcode_vld,
  output logic                err,
  output logic [DATA_W-1:0]   sfr_rdata
);
  localparam int ADDR_W = 2 * DATA_W;

  bus_sel_e dec_sel, sel_q, cur_sel;
  logic     dec_inv;
  logic     slot_first, slot_last, addr_win, strobe_win, second_slot;
  logic     io_err, skip, go, act_q;
  logic [DATA_W-1:0] p5_reg, p6_reg;
  logic [DATA_W-1:0] p0_q, p2_q, sec_lo_q, sec_hi_q, opc_q;
  logic ale_q, pri_q, sec_q, p0_oe_q, sec_oe_q, vld_q, err_q;

  pfs_mode_decode #(.ADDR_W(ADDR_W), .SPLIT(SPLIT)) u_dec (
    .bus_en (bus_en),
    .ext_acc(ext_acc),
    .addr   (fetch_addr),
    .sel    (dec_sel),
    .invalid(dec_inv)
  );

  pfs_slot_timing #(.PH_W(PH_W), .SLOT_PH(SLOT_PH)) u_tim (
    .phase      (phase),
    .slot_first (slot_first),
    .slot_last  (slot_last),
    .addr_win   (addr_win),
    .strobe_win (strobe_win),
    .second_slot(second_slot)
  );

  pfs_port_regs #(
    .DATA_W(DATA_W), .SFR_AW(SFR_AW), .P5_ADDR(P5_ADDR), .P6_ADDR(P6_ADDR)
  ) u_ports (
    .clk      (clk),
    .rst      (rst),
    .bus_en   (bus_en),
    .sfr_wr   (sfr_wr),
    .sfr_rd   (sfr_rd),
    .sfr_addr (sfr_addr),
    .sfr_wdata(sfr_wdata),
    .p5_reg   (p5_reg),
    .p6_reg   (p6_reg),
    .sfr_rdata(sfr_rdata),
    .io_err   (io_err)
  );

  // A slot becomes active at its first phase; a data cycle claims slot two.
  always_comb begin
    skip    = second_slot && xdata_cyc;
    cur_sel = slot_first ? dec_sel : sel_q;
    go      = !dec_inv && !skip &&
              (slot_first ? (fetch_req && dec_sel != BUS_NONE) : act_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      sel_q    <= BUS_NONE;
      ale_q    <= 1'b0;
      pri_q    <= 1'b0;
      sec_q    <= 1'b0;
      p0_oe_q  <= 1'b0;
      sec_oe_q <= 1'b0;
      p0_q     <= '0;
      p2_q     <= '0;
      sec_lo_q <= '0;
      sec_hi_q <= '0;
      opc_q    <= '0;
      vld_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      act_q    <= go && !slot_last;
      ale_q    <= go && slot_first;
      pri_q    <= go && cur_sel == BUS_PRI && strobe_win;
      sec_q    <= go && cur_sel == BUS_SEC && strobe_win;
      p0_oe_q  <= go && cur_sel == BUS_PRI && addr_win;
      sec_oe_q <= go && cur_sel == BUS_SEC && addr_win;
      vld_q    <= go && slot_last;
      err_q    <= dec_inv || io_err;
      if (go && slot_first) begin
        sel_q <= dec_sel;
        if (dec_sel == BUS_PRI) begin
          p0_q <= fetch_addr[DATA_W-1:0];
          p2_q <= fetch_addr[ADDR_W-1:DATA_W];
        end else begin
          sec_lo_q <= fetch_addr[DATA_W-1:0];
          sec_hi_q <= fetch_addr[ADDR_W-1:DATA_W];
        end
      end
      if (go && slot_last)
        opc_q <= (cur_sel == BUS_PRI) ? p0_in : p5_in;
    end
  end

  assign ale        = ale_q;
  assign pri_rd     = pri_q;
  assign sec_rd     = sec_q;
  assign p0_out     = p0_q;
  assign p0_oe      = p0_oe_q;
  assign p2_out     = p2_q;
  assign p5_out     = bus_en ? sec_lo_q : p5_reg;
  assign p5_oe      = bus_en ? sec_oe_q : 1'b1;
  assign p6_out     = bus_en ? sec_hi_q : p6_reg;
  assign opcode     = opc_q;
  assign opcode_vld = vld_q;
  assign err        = err_q;
endmodule

// File: rtl/pfs_fetch_steer_chk.sv
module pfs_fetch_steer_chk #(
  parameter int PH_W    = 4,
  parameter int SLOT_PH = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_en,
  input logic            ext_acc,
  input logic [PH_W-1:0] phase,
  input logic            xdata_cyc,
  input logic            ale,
  input logic            pri_rd,
  input logic            sec_rd,
  input logic            opcode_vld,
  input logic            err
);
  localparam logic [PH_W-1:0] SLOT_V = PH_W'(SLOT_PH);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pri_rd && sec_rd)); // R6
  AST_ALE_NOT_STROBE: assert property (@(posedge clk) disable iff (rst)
    ale |-> !(pri_rd || sec_rd)); // R6
  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!bus_en && ext_acc) |=> (!ale && !pri_rd && !sec_rd && err)); // R2
  AST_LOWMODE_NO_SEC: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> !sec_rd); // R1
  AST_EXTLOW_NO_PRI: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !ext_acc) |=> !pri_rd); // R3
  AST_XDATA_SKIP: assert property (@(posedge clk) disable iff (rst)
    (phase >= SLOT_V && xdata_cyc) |=> (!ale && !pri_rd && !sec_rd)); // R7
  AST_VLD_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    opcode_vld |-> (pri_rd || sec_rd)); // R8
endmodule

bind pfs_fetch_steer pfs_fetch_steer_chk #(.PH_W(pfs_pkg::PH_W), .SLOT_PH(pfs_pkg::SLOT_PH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_en    (bus_en),
  .ext_acc   (ext_acc),
  .phase     (phase),
  .xdata_cyc (xdata_cyc),
  .ale       (ale),
  .pri_rd    (pri_rd),
  .sec_rd    (sec_rd),
  .opcode_vld(opcode_vld),
  .err       (err)
);

// File: tb/sim_pfs_fetch_steer.sv
module sim_pfs_fetch_steer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b0, ext_acc = 1'b0, fetch_req = 1'b0, xdata_cyc = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic [3:0]  phase = '0;
  logic [7:0]  p0_in = '0, p5_in = '0;
  logic sfr_wr = 1'b0, sfr_rd = 1'b0;
  logic [7:0] sfr_addr = '0, sfr_wdata = '0;
  logic ale, pri_rd, sec_rd, p0_oe, p5_oe, opcode_vld, err;
  logic [7:0] p0_out, p2_out, p5_out, p6_out, opcode, sfr_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pfs_fetch_steer u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .ext_acc(ext_acc),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .phase(phase),
    .xdata_cyc(xdata_cyc), .p0_in(p0_in), .p5_in(p5_in),
    .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .ale(ale), .pri_rd(pri_rd), .sec_rd(sec_rd), .p0_out(p0_out), .p0_oe(p0_oe),
    .p2_out(p2_out), .p5_out(p5_out), .p5_oe(p5_oe), .p6_out(p6_out),
    .opcode(opcode), .opcode_vld(opcode_vld), .err(err), .sfr_rdata(sfr_rdata)
  );

  // {bus_en, ext_acc, xdata, expected bus (0 none, 1 primary, 2 secondary), address}
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 2'd1, 16'h1234},
    {1'b0, 1'b1, 1'b0, 2'd0, 16'h1234},
    {1'b1, 1'b0, 1'b0, 2'd2, 16'hABCD},
    {1'b1, 1'b1, 1'b0, 2'd2, 16'h1FFF},
    {1'b1, 1'b1, 1'b0, 2'd1, 16'h2000},
    {1'b1, 1'b1, 1'b1, 2'd2, 16'h0000},
    {1'b0, 1'b0, 1'b1, 2'd1, 16'hFFFF},
    {1'b1, 1'b0, 1'b1, 2'd2, 16'hF000}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  int ale_n, pri_n, sec_n, vld_n, first_k, addr_bad, err_n;
  logic [7:0] last_op;

  task automatic run_cycle(input logic [20:0] v);
    logic [1:0] eb;
    int slots;
    string tag;
    logic [7:0] exp_op;
    eb = v[17:16];
    @(negedge clk);
    bus_en = v[20]; ext_acc = v[19]; xdata_cyc = v[18];
    fetch_addr = v[15:0]; fetch_req = 1'b1;
    p0_in = v[7:0] ^ 8'h5A; p5_in = v[15:8] ^ 8'h3C;
    ale_n = 0; pri_n = 0; sec_n = 0; vld_n = 0; first_k = -1; addr_bad = 0; err_n = 0;
    last_op = '0;
    for (int k = 0; k <= 12; k++) begin
      if (k > 0) begin
        if (ale) begin
          ale_n++;
          if (eb == 2'd1 && !(p0_out == v[7:0] && p2_out == v[15:8] && p0_oe)) addr_bad++;
          if (eb == 2'd2 && !(p5_out == v[7:0] && p6_out == v[15:8] && p5_oe)) addr_bad++;
        end
        if (pri_rd) pri_n++;
        if (sec_rd) sec_n++;
        if ((pri_rd || sec_rd) && first_k < 0) first_k = k;
        if (opcode_vld) begin vld_n++; last_op = opcode; end
        if (err) err_n++;
      end
      if (k < 12) begin
        phase = 4'(k);
        @(negedge clk);
      end
    end
    fetch_req = 1'b0; xdata_cyc = 1'b0; phase = '0;
    if (v[18]) tag = "R7";
    else if (!v[20] && !v[19]) tag = "R1";
    else if (!v[20]) tag = "R2";
    else if (!v[19]) tag = "R3";
    else tag = "R4";
    slots = v[18] ? 1 : 2;
    if (eb == 2'd0) begin
      check(ale_n == 0 && pri_n == 0 && sec_n == 0 && vld_n == 0, tag, pri_n + sec_n + ale_n, 0);
      check(err_n == 12, "R2 err", err_n, 12);
    end else begin
      check(pri_n == (eb == 2'd1 ? 3 * slots : 0), {tag, " pri"}, pri_n, eb == 2'd1 ? 3 * slots : 0);
      check(sec_n == (eb == 2'd2 ? 3 * slots : 0), {tag, " sec"}, sec_n, eb == 2'd2 ? 3 * slots : 0);
      check(ale_n == slots, {tag, " ale"}, ale_n, slots);
      check(err_n == 0, {tag, " err"}, err_n, 0);
      check(addr_bad == 0 && ale_n > 0, "R5 address", addr_bad, 0);
      check(first_k == 4, "R6 strobe start", first_k, 4);
      exp_op = (eb == 2'd1) ? (v[7:0] ^ 8'h5A) : (v[15:8] ^ 8'h3C);
      check(vld_n == slots && last_op == exp_op, "R8 opcode", last_op, exp_op);
    end
  endtask

  task automatic sfr_access(input bit wr, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_wr = wr; sfr_rd = !wr; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr = 1'b0; sfr_rd = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check(!ale && !pri_rd && !sec_rd && !opcode_vld && !err, "R11 controls", {ale, pri_rd, sec_rd, opcode_vld, err}, 0);
    check(p5_out == 8'hFF && p6_out == 8'hFF, "R11 ports", {p5_out, p6_out}, 16'hFFFF);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_cycle(VEC[i]);

    bus_en = 1'b0; ext_acc = 1'b0;
    sfr_access(1'b1, 8'h91, 8'h3C);
    check(p5_out == 8'h3C, "R9 p5 write", p5_out, 8'h3C);
    sfr_access(1'b1, 8'hA1, 8'hC3);
    check(p6_out == 8'hC3, "R9 p6 write", p6_out, 8'hC3);
    sfr_access(1'b1, 8'h90, 8'h00);
    sfr_access(1'b1, 8'hA0, 8'h00);
    check(p5_out == 8'h3C && p6_out == 8'hC3, "R9 row addr ignored", {p5_out, p6_out}, 16'h3CC3);
    @(negedge clk);
    sfr_rd = 1'b1; sfr_addr = 8'h91;
    @(negedge clk);
    sfr_rd = 1'b0;
    check(sfr_rdata == 8'h3C && !err, "R9 read", sfr_rdata, 8'h3C);

    bus_en = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b1; sfr_addr = 8'h91; sfr_wdata = 8'h55;
    @(negedge clk);
    sfr_wr = 1'b0;
    check(err == 1'b1, "R10 write err", err, 1);
    sfr_rd = 1'b1; sfr_addr = 8'hA1;
    @(negedge clk);
    sfr_rd = 1'b0;
    check(err == 1'b1 && sfr_rdata == 8'h00, "R10 read", {err, sfr_rdata}, 9'h100);
    bus_en = 1'b0;
    @(negedge clk);
    check(p5_out == 8'h3C && p6_out == 8'hC3 && !err, "R10 unchanged", {p5_out, p6_out}, 16'h3CC3);

    summary();
  end
endmodule